// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block forms the byte address for a load or store from a pointer register and a signed byte offset. It also forms the value that the pointer takes back. Three addressing forms are supported. Post-increment uses the pointer as the address and then advances it. Pre-increment advances the pointer and uses the advanced value as the address. Pre-offset uses the pointer plus the offset as the address and leaves the pointer as it was.

Eight of the thirty-two pointer registers can run in circular mode. These are numbers 4 to 7 on side A and on side B. A 32-bit mode word gives each of these eight a 2-bit mode field, and it holds two block-size exponents. In circular mode only the low bits that lie inside a block of 2^(N+1) bytes take part in the add. The high bits of the pointer pass through unchanged, so a buffer aligned to its own size wraps at both ends.

The request is registered once. The results appear one clock after the request, together with a flag that says whether the pointer should be written back.

Top module: `circ_agu`

## Requirements
- R1: While rst_n is low, and after it is released until the first request, rsp_valid, eff_addr, new_ptr and upd_en are all zero.
- R2: rsp_valid is high in the cycle after req_valid was high and low otherwise. When no request arrives, eff_addr, new_ptr and upd_en keep their values.
- R3: Post-increment (form code 0): eff_addr equals the pointer, and new_ptr equals the pointer advanced by the offset.
- R4: Pre-increment with update (form code 1): eff_addr and new_ptr both equal the pointer advanced by the offset.
- R5: Pre-offset without update (form code 2, and also the unused code 3): eff_addr equals the pointer advanced by the offset, and new_ptr equals the unchanged pointer.
- R6: ptr_idx bit 4 selects side B when it is 1, and bits 3:0 give the register number. Only register numbers 4 to 7 may be circular. Every other pointer is advanced linearly over the full width, whatever the mode word holds.
- R7: The field of an eligible pointer sits at mode_word bits [2k+1:2k], with k = 4*side + (number - 4), so side A 4..7 takes k = 0..3 and side B 4..7 takes k = 4..7. Field 00 means linear, 01 means circular with N from bits 20:16, 10 means circular with N from bits 25:21, and 11 is treated as linear.
- R8: In circular mode the low N+1 address bits come from pointer plus offset, and the bits above them come from the pointer. A step past the top of the block therefore lands at its start. With N = 31 the whole word wraps.
- R9: In circular mode a negative offset that crosses below the start of the block lands near its end. An example is base offset 4 with a step of -8 in a 64-byte block, which gives block offset 60.
- R10: upd_en is 1 for form codes 0 and 1 and 0 for codes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| ptr_idx | input | 5 | Pointer register: bit 4 side, bits 3:0 number |
| form | input | 2 | Addressing form code |
| mode_word | input | 32 | Addressing-mode word (fields and block sizes) |
| base | input | ADDR_W | Current pointer value |
| offset | input | OFF_W | Signed byte offset |
| rsp_valid | output | 1 | Results valid |
| eff_addr | output | ADDR_W | Effective byte address |
| new_ptr | output | ADDR_W | Pointer value to write back |
| upd_en | output | 1 | Pointer write-back wanted |

## Verification
On every cycle the assertions check four things. They check the one-cycle response timing and that the outputs hold between requests. They check the address and write-back relations between the three forms. They check that a pointer outside numbers 4 to 7 always gets a plain full-width sum. The outcome of a wrap is left to the bench scenarios. These cover where each pointer's field sits in the mode word, the choice of block-size exponent, wraps upward and downward, and the preservation of the high bits. Each such scenario has hand-computed expected values.

// File: rtl/circ_agu_pkg.sv
package circ_agu_pkg;
   localparam int MODE_W      = 32;
   localparam int FIELD_W     = 2;
   localparam int BK_W        = 5;
   localparam int BK_LO_LSB   = 16;
   localparam int BK_HI_LSB   = 21;
   localparam int PTR_IDX_W   = 5;

   typedef enum logic [1:0] {
      FORM_POST   = 2'd0,
      FORM_PREINC = 2'd1,
      FORM_PREOFF = 2'd2,
      FORM_ALT    = 2'd3
   } form_e;

   typedef enum logic [1:0] {
      WRAP_NONE = 2'b00,
      WRAP_LO   = 2'b01,
      WRAP_HI   = 2'b10,
      WRAP_RSVD = 2'b11
   } wrap_e;
endpackage

// File: rtl/agu_mode_decode.sv
module agu_mode_decode
   import circ_agu_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter bit HAS_CIRC = 1'b1
) (
   input  logic [PTR_IDX_W-1:0] ptr_idx,
   input  logic [MODE_W-1:0]    mode_word,
   output logic                 circ,
   output logic [ADDR_W-1:0]    mask
);
   generate
      if (HAS_CIRC) begin : g_circ
         logic [2:0]         slot;
         logic               eligible;
         logic [FIELD_W-1:0] field;
         logic [BK_W-1:0]    n_exp;

         always_comb begin
            slot     = {ptr_idx[4], ptr_idx[1:0]};
            eligible = (ptr_idx[3:2] == 2'b01);
            field    = mode_word[FIELD_W*slot +: FIELD_W];
            n_exp    = (field == WRAP_LO) ? mode_word[BK_LO_LSB +: BK_W]
                                          : mode_word[BK_HI_LSB +: BK_W];
            circ     = eligible && ((field == WRAP_LO) || (field == WRAP_HI));
            for (int i = 0; i < ADDR_W; i++) begin
               mask[i] = (i <= int'(n_exp));
            end
         end
      end else begin : g_lin
         always_comb begin
            circ = 1'b0;
            mask = '0;
         end
      end
   endgenerate
endmodule

// File: rtl/agu_wrap_add.sv
module agu_wrap_add #(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 16
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [OFF_W-1:0]  offset,
   input  logic              circ,
   input  logic [ADDR_W-1:0] mask,
   output logic [ADDR_W-1:0] result
);
   logic [ADDR_W-1:0] off_ext;
   logic [ADDR_W-1:0] sum;

   always_comb begin
      off_ext = ADDR_W'($signed(offset));
      sum     = base + off_ext;
      result  = circ ? ((base & ~mask) | (sum & mask)) : sum;
   end
endmodule

// File: rtl/agu_form_sel.sv
module agu_form_sel
   import circ_agu_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [1:0]        form,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] stepped,
   output logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] ptr,
   output logic              upd
);
   always_comb begin
      unique case (form_e'(form))
         FORM_POST:   begin addr = base;    ptr = stepped; upd = 1'b1; end
         FORM_PREINC: begin addr = stepped; ptr = stepped; upd = 1'b1; end
         default:     begin addr = stepped; ptr = base;    upd = 1'b0; end
      endcase
   end
endmodule

// File: rtl/circ_agu.sv
module circ_agu
   import circ_agu_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int OFF_W    = 16,
   parameter bit HAS_CIRC = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [PTR_IDX_W-1:0] ptr_idx,
   input  logic [1:0]           form,
   input  logic [MODE_W-1:0]    mode_word,
   input  logic [ADDR_W-1:0]    base,
   input  logic [OFF_W-1:0]     offset,
   output logic                 rsp_valid,
   output logic [ADDR_W-1:0]    eff_addr,
   output logic [ADDR_W-1:0]    new_ptr,
   output logic                 upd_en
);
   generate
      if (ADDR_W < 8)      begin : g_bad_aw  $error("ADDR_W below 8");      end
      if (OFF_W > ADDR_W)  begin : g_bad_ow  $error("OFF_W above ADDR_W"); end
      if (OFF_W < 2)       begin : g_bad_ow2 $error("OFF_W below 2");      end
   endgenerate

   logic              circ;
   logic [ADDR_W-1:0] mask;
   logic [ADDR_W-1:0] stepped;
   logic [ADDR_W-1:0] addr_c;
   logic [ADDR_W-1:0] ptr_c;
   logic              upd_c;

   agu_mode_decode #(.ADDR_W(ADDR_W), .HAS_CIRC(HAS_CIRC)) u_dec (
      .ptr_idx(ptr_idx), .mode_word(mode_word), .circ(circ), .mask(mask)
   );

   agu_wrap_add #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_add (
      .base(base), .offset(offset), .circ(circ), .mask(mask), .result(stepped)
   );

   agu_form_sel #(.ADDR_W(ADDR_W)) u_sel (
      .form(form), .base(base), .stepped(stepped),
      .addr(addr_c), .ptr(ptr_c), .upd(upd_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         eff_addr  <= '0;
         new_ptr   <= '0;
         upd_en    <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            eff_addr <= addr_c;
            new_ptr  <= ptr_c;
            upd_en   <= upd_c;
         end
      end
   end
endmodule

// File: rtl/circ_agu_chk.sv
module circ_agu_chk #(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [4:0]        ptr_idx,
   input logic [1:0]        form,
   input logic [ADDR_W-1:0] base,
   input logic [OFF_W-1:0]  offset,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] eff_addr,
   input logic [ADDR_W-1:0] new_ptr,
   input logic              upd_en
);
   logic [ADDR_W-1:0] full_sum;
   logic              may_wrap;
   assign full_sum = base + ADDR_W'($signed(offset));
   assign may_wrap = (ptr_idx[3:0] >= 4'd4) && (ptr_idx[3:0] <= 4'd7);

   AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R2
   AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid); // R2
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> ($stable(eff_addr) && $stable(new_ptr) && $stable(upd_en))); // R2
   AST_POST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && form == 2'd0) |=> (eff_addr == $past(base))); // R3
   AST_PREINC_SAME: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && form == 2'd1) |=> (eff_addr == new_ptr)); // R4
   AST_PREOFF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && form[1]) |=> (new_ptr == $past(base))); // R5
   AST_LINEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !may_wrap && form != 2'd0) |=> (eff_addr == $past(full_sum))); // R6
   AST_UPD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (upd_en == !$past(form[1]))); // R10
endmodule

bind circ_agu circ_agu_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ptr_idx(ptr_idx),
   .form(form), .base(base), .offset(offset), .rsp_valid(rsp_valid),
   .eff_addr(eff_addr), .new_ptr(new_ptr), .upd_en(upd_en)
);

// File: tb/sim_circ_agu.sv
module sim_circ_agu;
   localparam int AW = 32;
   localparam int OW = 16;
   localparam int NV = 14;

   typedef struct packed {
      logic [4:0]    ptr;
      logic [1:0]    form;
      logic [31:0]   mode;
      logic [AW-1:0] base;
      logic [OW-1:0] off;
      logic [AW-1:0] addr;
      logic [AW-1:0] nptr;
      logic          upd;
      logic [7:0]    req;
   } vec_t;

   // req column names the requirement each row exercises:
   // R3 post, R4 preinc, R5 preoff/alt, R6 ineligible, R7 field map, R8 up wrap, R9 down wrap
   localparam vec_t VECS [0:NV-1] = '{
      '{5'h05, 2'd0, 32'h0005_0004, 32'h0000_1038, 16'h0010, 32'h0000_1038, 32'h0000_1008, 1'b1, 8'd8},
      '{5'h05, 2'd1, 32'h0005_0004, 32'h0000_1004, 16'hFFF8, 32'h0000_103C, 32'h0000_103C, 1'b1, 8'd9},
      '{5'h05, 2'd1, 32'h0005_0004, 32'h0000_1010, 16'h0004, 32'h0000_1014, 32'h0000_1014, 1'b1, 8'd8},
      '{5'h16, 2'd2, 32'h0060_2000, 32'h2000_00FC, 16'h0008, 32'h2000_00F4, 32'h2000_00FC, 1'b0, 8'd7},
      '{5'h04, 2'd0, 32'h0005_0003, 32'h0000_103C, 16'h0008, 32'h0000_103C, 32'h0000_1044, 1'b1, 8'd7},
      '{5'h03, 2'd1, 32'hFFFF_FFFF, 32'h0000_103C, 16'h0008, 32'h0000_1044, 32'h0000_1044, 1'b1, 8'd6},
      '{5'h18, 2'd1, 32'hFFFF_FFFF, 32'h0000_003F, 16'h0001, 32'h0000_0040, 32'h0000_0040, 1'b1, 8'd6},
      '{5'h17, 2'd1, 32'h0000_4000, 32'h0000_0501, 16'h0001, 32'h0000_0500, 32'h0000_0500, 1'b1, 8'd8},
      '{5'h05, 2'd0, 32'h0000_0000, 32'h0000_0100, 16'hFFFC, 32'h0000_0100, 32'h0000_00FC, 1'b1, 8'd3},
      '{5'h05, 2'd3, 32'h0005_0004, 32'h0000_1038, 16'h0010, 32'h0000_1008, 32'h0000_1038, 1'b0, 8'd5},
      '{5'h07, 2'd2, 32'h0000_0000, 32'h0000_0200, 16'h0020, 32'h0000_0220, 32'h0000_0200, 1'b0, 8'd5},
      '{5'h06, 2'd1, 32'h03E0_0020, 32'hFFFF_FFF0, 16'h0020, 32'h0000_0010, 32'h0000_0010, 1'b1, 8'd8},
      '{5'h15, 2'd1, 32'h0005_0004, 32'h0000_1038, 16'h0010, 32'h0000_1048, 32'h0000_1048, 1'b1, 8'd7},
      '{5'h04, 2'd1, 32'h0000_0000, 32'h0000_0080, 16'h7FFF, 32'h0000_807F, 32'h0000_807F, 1'b1, 8'd4}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [4:0]    ptr_idx = '0;
   logic [1:0]    form = '0;
   logic [31:0]   mode_word = '0;
   logic [AW-1:0] base = '0;
   logic [OW-1:0] offset = '0;
   logic          rsp_valid;
   logic [AW-1:0] eff_addr;
   logic [AW-1:0] new_ptr;
   logic          upd_en;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   circ_agu #(.ADDR_W(AW), .OFF_W(OW)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ptr_idx(ptr_idx),
      .form(form), .mode_word(mode_word), .base(base), .offset(offset),
      .rsp_valid(rsp_valid), .eff_addr(eff_addr), .new_ptr(new_ptr), .upd_en(upd_en)
   );

   task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic issue(input vec_t v);
      @(negedge clk);
      req_valid = 1'b1;
      ptr_idx   = v.ptr;
      form      = v.form;
      mode_word = v.mode;
      base      = v.base;
      offset    = v.off;
      @(posedge clk);
      #1;
      req_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      check("R1 rsp_valid", AW'(rsp_valid), '0);
      check("R1 eff_addr", eff_addr, '0);
      check("R1 new_ptr", new_ptr, '0);
      check("R1 upd_en", AW'(upd_en), '0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check("R1 idle after release", AW'(rsp_valid), '0);

      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
         issue(VECS[i]);
         check({"R2 valid ", tag}, AW'(rsp_valid), AW'(1));
         check({tag, " addr"}, eff_addr, VECS[i].addr);
         check({tag, " ptr"}, new_ptr, VECS[i].nptr);
         check({"R10 upd ", tag}, AW'(upd_en), AW'(VECS[i].upd));
      end

      // R2: idle cycles hold outputs even as inputs change
      @(negedge clk);
      ptr_idx = 5'h05; form = 2'd1; mode_word = 32'h0005_0004;
      base = 32'hDEAD_0000; offset = 16'h0040;
      @(posedge clk);
      #1;
      check("R2 idle valid", AW'(rsp_valid), '0);
      check("R2 idle addr hold", eff_addr, 32'h0000_807F);
      check("R2 idle ptr hold", new_ptr, 32'h0000_807F);

      // R9: circular post-increment downward across the start (64-byte block)
      issue('{5'h05, 2'd0, 32'h0005_0004, 32'h0000_1000, 16'hFFFF, 32'h0000_1000, 32'h0000_103F, 1'b1, 8'd9});
      check("R9 down addr", eff_addr, 32'h0000_1000);
      check("R9 down ptr", new_ptr, 32'h0000_103F);

      // R1: reset reasserted clears outputs
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      #1;
      check("R1 re-reset addr", eff_addr, '0);
      check("R1 re-reset valid", AW'(rsp_valid), '0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog R2 actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule